// File: doc/BRIEF.md
# Staged Output Register and Wait Unit

This block executes a small stream of 32-bit command words for a general-purpose output port and for timed waits. Commands arrive on a valid/ready input fed by a FIFO. Two staging commands fill the low and high halves of a 32-bit staging register. A commit command copies the low 19 bits of that register onto the output lines. Until a commit arrives, staging writes do not touch the outputs.

Each command keeps the input stalled for a fixed execution time. The block assumes a 10 ns clock, so 30 ns becomes 3 cycles, 50 ns becomes 5 cycles, and one coarse wait unit of 100,000 ns becomes 10,000 cycles. A coarse delay command holds the stream for a number of these units. A no-op command holds it for a short, cycle-granular time. The stream controller upstream uses both to space its actions in time.

The occupancy of a command is the number of cycles from the clock edge that accepts it until `cmd_ready` is high again. The next command can be accepted that many cycles after the current one.

Top module: `gpo_cmd_exec`

## Requirements
- R1: After reset, `gpo` is all zeros, the staging register is all zeros and `cmd_ready` is high.
- R2: The opcode sits in bits [31:28] and the argument in bits [15:0]. Opcode 1 loads the argument into staging bits [15:0], and opcode 2 loads it into staging bits [31:16]. In both cases the other half of the staging register is unchanged.
- R3: Opcode 3 (commit) copies staging bits [18:0] onto `gpo` at the edge that accepts it. `gpo` changes at no other time, so staging writes alone never alter it.
- R4: A staging command occupies 3 cycles (30 ns) and a commit occupies 5 cycles (50 ns).
- R5: Opcode 5 (no-op) with argument n occupies 1 + n cycles (10 ns plus 10 ns per iteration) and has no other effect.
- R6: Opcode 4 (delay) with argument n occupies n × UNIT_CYC cycles, where UNIT_CYC is 100,000 ns divided by the clock period (10,000 cycles by default). A delay with n = 0 occupies one cycle.
- R7: Any other opcode (0 or 6 through 15) is consumed in one cycle and changes neither the staging register nor `gpo`.
- R8: `cmd_ready` stays low for the whole occupancy of a command. A word held valid during that time is not consumed until `cmd_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 10 ns period |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word present |
| cmd_data | input | 32 | Command word: opcode [31:28], argument [15:0] |
| cmd_ready | output | 1 | Block can accept a command this cycle |
| gpo | output | 19 | General-purpose output lines |

## Verification
The bench sweeps no-op arguments and delay iteration counts across the boundary between a zero argument and a non-zero one, including the largest no-op argument and a delay that needs many unit reloads. A timer that reloaded one cycle short, or that treated a zero-iteration delay as a full unit, would report a wrong occupancy. Walking-bit and mixed staging patterns, written in both half orders and with partial rewrites, catch a swapped half, a clobbered neighbour half or a commit that drops bits 16 to 18. A word held valid through a busy window shows whether a design consumed it early. Every undefined opcode is checked for any side effect on the staging register, which would only appear on the next commit.

// File: rtl/gpo_cmd_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the staged output executor: opcode values,
// field positions of the command word and the decoded command record.
package gpo_cmd_pkg;

    localparam int CMD_W   = 32;
    localparam int OPC_LSB = 28;
    localparam int OPC_W   = 4;
    localparam int ARG_W   = 16;

    typedef enum logic [OPC_W-1:0] {
        OPC_STAGE_LO = 4'h1,
        OPC_STAGE_HI = 4'h2,
        OPC_COMMIT   = 4'h3,
        OPC_DELAY    = 4'h4,
        OPC_NOP      = 4'h5
    } opc_e;

    typedef struct packed {
        logic             stage_lo;
        logic             stage_hi;
        logic             commit;
        logic             delay;
        logic             nop;
        logic [ARG_W-1:0] arg;
    } cmd_dec_t;

endpackage

// File: rtl/gpo_cmd_decode.sv
`timescale 1ns/1ps
// Command decoder: splits a command word into one-hot operation flags
// and the argument field. Assumes the opcode lives in the top nibble;
// unknown opcodes yield no flags, so they act as one-cycle no-effect words.
module gpo_cmd_decode
    import gpo_cmd_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_data,
    output cmd_dec_t         dec
);

    logic [OPC_W-1:0]         opc;
    logic [OPC_LSB-ARG_W-1:0] unused_mid;

    assign opc        = cmd_data[OPC_LSB +: OPC_W];
    assign unused_mid = cmd_data[OPC_LSB-1:ARG_W];

    // Raise exactly one flag for a known opcode, none otherwise.
    always_comb begin
        dec          = '0;
        dec.arg      = cmd_data[ARG_W-1:0];
        dec.stage_lo = (opc == OPC_STAGE_LO);
        dec.stage_hi = (opc == OPC_STAGE_HI);
        dec.commit   = (opc == OPC_COMMIT);
        dec.delay    = (opc == OPC_DELAY);
        dec.nop      = (opc == OPC_NOP);
    end

endmodule

// File: rtl/gpo_stage_reg.sv
`timescale 1ns/1ps
// Double-buffered output register: two half-word writes fill a staging
// register, and a commit moves its low OUT_W bits to the outputs.
// Assumes at most one of the write/commit strobes is high per cycle.
module gpo_stage_reg #(
    parameter int STAGE_W = 32,
    parameter int OUT_W   = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic               commit,
    input  logic [STAGE_W/2-1:0] arg,
    output logic [STAGE_W-1:0] staged,
    output logic [OUT_W-1:0]   gpo
);

    localparam int HALF_W = STAGE_W / 2;

    // Staging register: each half is written on its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
        end else if (wr_lo) begin
            staged[HALF_W-1:0] <= arg;
        end else if (wr_hi) begin
            staged[STAGE_W-1:HALF_W] <= arg;
        end
    end

    // Output register: loads from staging only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpo <= '0;
        end else if (commit) begin
            gpo <= staged[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/gpo_wait_timer.sv
`timescale 1ns/1ps
// Occupancy timer: on load it starts a countdown whose length matches the
// accepted command's execution time, and it reports busy until it runs out.
// Long waits use a unit counter that reloads a fine counter, so only one
// unit's worth of fine counter is needed. Assumes load only when not busy.
module gpo_wait_timer
    import gpo_cmd_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int STAGE_NS    = 30,
    parameter int COMMIT_NS   = 50,
    parameter int NOP_BASE_NS = 10,
    parameter int NOP_STEP_NS = 10,
    parameter int UNIT_NS     = 100000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  cmd_dec_t dec,
    output logic     busy
);

    localparam int STAGE_CYC    = (STAGE_NS    / CLK_NS < 1) ? 1 : STAGE_NS    / CLK_NS;
    localparam int COMMIT_CYC   = (COMMIT_NS   / CLK_NS < 1) ? 1 : COMMIT_NS   / CLK_NS;
    localparam int NOP_BASE_CYC = (NOP_BASE_NS / CLK_NS < 1) ? 1 : NOP_BASE_NS / CLK_NS;
    localparam int NOP_STEP_CYC = NOP_STEP_NS / CLK_NS;
    localparam int UNIT_CYC     = (UNIT_NS     / CLK_NS < 1) ? 1 : UNIT_NS     / CLK_NS;
    localparam int NOP_MAX      = NOP_BASE_CYC + ((1 << ARG_W) - 1) * NOP_STEP_CYC;
    localparam int MAX_A        = (UNIT_CYC > NOP_MAX) ? UNIT_CYC : NOP_MAX;
    localparam int MAX_B        = (STAGE_CYC > COMMIT_CYC) ? STAGE_CYC : COMMIT_CYC;
    localparam int FINE_MAX     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int FINE_W       = $clog2(FINE_MAX + 1);

    logic [FINE_W-1:0] fine_cnt, fine_ld;
    logic [ARG_W-1:0]  unit_cnt, unit_ld;
    logic [FINE_W-1:0] nop_len;

    // No-op length beyond the accepting cycle: base minus one plus steps.
    generate
        if (NOP_STEP_CYC == 0) begin : g_nop_flat
            assign nop_len = FINE_W'(NOP_BASE_CYC - 1);
        end else begin : g_nop_scaled
            assign nop_len = FINE_W'(NOP_BASE_CYC - 1)
                           + FINE_W'(dec.arg) * FINE_W'(NOP_STEP_CYC);
        end
    endgenerate

    // Select the countdown that matches the decoded command.
    always_comb begin
        fine_ld = '0;
        unit_ld = '0;
        if (dec.stage_lo || dec.stage_hi) begin
            fine_ld = FINE_W'(STAGE_CYC - 1);
        end else if (dec.commit) begin
            fine_ld = FINE_W'(COMMIT_CYC - 1);
        end else if (dec.nop) begin
            fine_ld = nop_len;
        end else if (dec.delay && (dec.arg != '0)) begin
            fine_ld = FINE_W'(UNIT_CYC - 1);
            unit_ld = dec.arg - 1'b1;
        end
    end

    // Count down fine cycles, reloading one unit at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_cnt <= '0;
            unit_cnt <= '0;
        end else if (load) begin
            fine_cnt <= fine_ld;
            unit_cnt <= unit_ld;
        end else if (fine_cnt != '0) begin
            fine_cnt <= fine_cnt - 1'b1;
        end else if (unit_cnt != '0) begin
            unit_cnt <= unit_cnt - 1'b1;
            fine_cnt <= FINE_W'(UNIT_CYC - 1);
        end
    end

    // Busy while any part of the countdown remains.
    assign busy = (fine_cnt != '0) || (unit_cnt != '0);

endmodule

// File: rtl/gpo_cmd_exec.sv
`timescale 1ns/1ps
// Command executor for a staged general-purpose output port and timed
// waits. Accepts one command per valid/ready handshake, applies staging or
// commit at the accepting edge, and holds ready low for the command's
// execution time. Assumes a clock of CLK_NS nanoseconds.
module gpo_cmd_exec
    import gpo_cmd_pkg::*;
#(
    parameter int OUT_W       = 19,
    parameter int STAGE_W     = 32,
    parameter int CLK_NS      = 10,
    parameter int STAGE_NS    = 30,
    parameter int COMMIT_NS   = 50,
    parameter int NOP_BASE_NS = 10,
    parameter int NOP_STEP_NS = 10,
    parameter int UNIT_NS     = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_data,
    output logic             cmd_ready,
    output logic [OUT_W-1:0] gpo
);

    cmd_dec_t           dec;
    logic               accept;
    logic               busy;
    logic [STAGE_W-1:0] staged;

    // Handshake: a word is taken whenever the timer is idle.
    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;

    gpo_cmd_decode u_decode (
        .cmd_data (cmd_data),
        .dec      (dec)
    );

    gpo_stage_reg #(
        .STAGE_W (STAGE_W),
        .OUT_W   (OUT_W)
    ) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (accept && dec.stage_lo),
        .wr_hi  (accept && dec.stage_hi),
        .commit (accept && dec.commit),
        .arg    (dec.arg),
        .staged (staged),
        .gpo    (gpo)
    );

    gpo_wait_timer #(
        .CLK_NS      (CLK_NS),
        .STAGE_NS    (STAGE_NS),
        .COMMIT_NS   (COMMIT_NS),
        .NOP_BASE_NS (NOP_BASE_NS),
        .NOP_STEP_NS (NOP_STEP_NS),
        .UNIT_NS     (UNIT_NS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .dec   (dec),
        .busy  (busy)
    );

endmodule

// File: rtl/gpo_cmd_exec_chk.sv
`timescale 1ns/1ps
// Property checker for the staged output executor, bound to the top.
module gpo_cmd_exec_chk #(
    parameter int OUT_W   = 19,
    parameter int STAGE_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [31:0]        cmd_data,
    input logic [OUT_W-1:0]   gpo,
    input logic [STAGE_W-1:0] staged
);

    logic       acc;
    logic [3:0] op;
    logic       commit_q;

    assign acc = cmd_valid && cmd_ready;
    assign op  = cmd_data[31:28];

    // Remember whether the previous edge accepted a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) commit_q <= 1'b0;
        else        commit_q <= acc && (op == 4'h3);
    end

    // R3
    gpo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_q |-> $stable(gpo));

    // R3
    gpo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == 4'h3) |=> gpo == $past(staged[OUT_W-1:0]));

    // R2
    stage_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == 4'h1) |=>
            (staged[15:0] == $past(cmd_data[15:0])) && (staged[31:16] == $past(staged[31:16])));

    // R2
    stage_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == 4'h2) |=>
            (staged[31:16] == $past(cmd_data[15:0])) && (staged[15:0] == $past(staged[15:0])));

    // R4
    stage_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (op == 4'h1 || op == 4'h2 || op == 4'h3)) |=> !cmd_ready);

    // R6
    delay_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == 4'h4 && cmd_data[15:0] == 16'h0) |=> cmd_ready);

    // R7
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (op == 4'h0 || op > 4'h5)) |=> cmd_ready && $stable(staged));

endmodule

bind gpo_cmd_exec gpo_cmd_exec_chk #(
    .OUT_W   (OUT_W),
    .STAGE_W (STAGE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .gpo       (gpo),
    .staged    (staged)
);

// File: tb/gpo_cmd_exec_tb.sv
`timescale 1ns/1ps
module gpo_cmd_exec_tb;

    localparam int OUT_W    = 19;
    localparam int UNIT_NS  = 200;
    localparam int UNIT_CYC = UNIT_NS / 10;
    localparam int WD_LIMIT = 190000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [31:0]       cmd_data = '0;
    logic              cmd_ready;
    logic [OUT_W-1:0]  gpo;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [31:0]      exp_staged = '0;
    logic [OUT_W-1:0] exp_gpo    = '0;

    always #2.5 clk = ~clk;

    gpo_cmd_exec #(.UNIT_NS(UNIT_NS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .cmd_ready (cmd_ready),
        .gpo       (gpo)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WD_LIMIT && !done) begin
            done = 1'b1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run exceeded %0d cycles", WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [15:0] arg);
        return {op, 12'h000, arg};
    endfunction

    // Send one word; return occupancy in cycles (accept edge to ready high).
    task automatic issue(input logic [31:0] w, output int occ);
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R8", "ready before issue", cmd_ready, 1);
        cmd_valid = 1'b1;
        cmd_data  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        occ = 1;
        while (cmd_ready !== 1'b1 && occ < 150000) begin
            @(negedge clk);
            occ++;
        end
    endtask

    task automatic stage_lo(input logic [15:0] v);
        int occ;
        issue(mk(4'h1, v), occ);
        exp_staged[15:0] = v;
        chk(occ == 3, "R4", "stage lo occupancy", occ, 3);
        chk(gpo == exp_gpo, "R3", "gpo after stage lo", gpo, exp_gpo);
    endtask

    task automatic stage_hi(input logic [15:0] v);
        int occ;
        issue(mk(4'h2, v), occ);
        exp_staged[31:16] = v;
        chk(occ == 3, "R4", "stage hi occupancy", occ, 3);
        chk(gpo == exp_gpo, "R3", "gpo after stage hi", gpo, exp_gpo);
    endtask

    task automatic commit_chk(input string req);
        int occ;
        issue(mk(4'h3, 16'h0), occ);
        exp_gpo = exp_staged[OUT_W-1:0];
        chk(occ == 5, "R4", "commit occupancy", occ, 5);
        chk(gpo == exp_gpo, req, "gpo after commit", gpo, exp_gpo);
    endtask

    initial begin
        int occ;
        int k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports, then a commit exposes zero staging.
        chk(gpo == '0, "R1", "gpo after reset", gpo, 0);
        chk(cmd_ready === 1'b1, "R1", "ready after reset", cmd_ready, 1);
        commit_chk("R1");

        // R2/R3: walking one through every staging bit.
        for (int b = 0; b < 32; b++) begin
            logic [31:0] v;
            v = 32'h1 << b;
            stage_lo(v[15:0]);
            stage_hi(v[31:16]);
            commit_chk("R2");
        end

        // R2/R3: mixed patterns, both half orders, partial rewrites.
        for (int i = 0; i < 24; i++) begin
            logic [15:0] lo;
            logic [15:0] hi;
            lo = 16'(i * 16'h9E37 + 16'h1234);
            hi = 16'(i * 16'h7F4A ^ 16'hC3A5);
            if (i % 3 == 0) begin
                stage_hi(hi);
                stage_lo(lo);
            end else if (i % 3 == 1) begin
                stage_lo(lo);
                stage_hi(hi);
            end else begin
                stage_lo(lo);
            end
            commit_chk("R2");
        end

        // R5: no-op occupancy sweep, including the largest argument.
        for (int n = 0; n <= 40; n++) begin
            issue(mk(4'h5, 16'(n)), occ);
            chk(occ == 1 + n, "R5", "nop occupancy", occ, 1 + n);
        end
        issue(mk(4'h5, 16'hFFFF), occ);
        chk(occ == 65536, "R5", "nop max occupancy", occ, 65536);
        chk(gpo == exp_gpo, "R5", "gpo after nop", gpo, exp_gpo);

        // R6: delay occupancy sweep, zero iterations and a long run.
        for (int n = 0; n <= 6; n++) begin
            int e;
            e = (n == 0) ? 1 : n * UNIT_CYC;
            issue(mk(4'h4, 16'(n)), occ);
            chk(occ == e, "R6", "delay occupancy", occ, e);
        end
        issue(mk(4'h4, 16'd250), occ);
        chk(occ == 250 * UNIT_CYC, "R6", "long delay occupancy", occ, 250 * UNIT_CYC);
        chk(gpo == exp_gpo, "R6", "gpo after delay", gpo, exp_gpo);

        // R7: undefined opcodes, full argument, no side effect.
        for (int op = 0; op < 16; op++) begin
            if (op >= 1 && op <= 5) continue;
            issue({4'(op), 12'hFFF, 16'hFFFF}, occ);
            chk(occ == 1, "R7", "unknown op occupancy", occ, 1);
            chk(gpo == exp_gpo, "R7", "gpo after unknown op", gpo, exp_gpo);
        end
        commit_chk("R7");

        // R8: word held valid during a staging write waits for ready.
        stage_hi(16'h0005);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = mk(4'h1, 16'h5A5A);
        exp_staged[15:0] = 16'h5A5A;
        @(negedge clk);
        cmd_data = mk(4'h3, 16'h0);
        k = 0;
        while (cmd_ready !== 1'b1 && k < 100) begin
            k++;
            chk(gpo == exp_gpo, "R8", "gpo while held word waits", gpo, exp_gpo);
            @(negedge clk);
        end
        chk(k == 2, "R8", "held word wait cycles", k, 2);
        @(negedge clk);
        cmd_valid = 1'b0;
        exp_gpo = exp_staged[OUT_W-1:0];
        chk(gpo == exp_gpo, "R8", "gpo after held commit", gpo, exp_gpo);
        chk(cmd_ready === 1'b0, "R8", "ready during held commit", cmd_ready, 0);
        occ = 1;
        while (cmd_ready !== 1'b1 && occ < 100) begin
            @(negedge clk);
            occ++;
        end
        chk(occ == 5, "R4", "held commit occupancy", occ, 5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule